// File: doc/BRIEF.md
# SPI Register Access Sequencer

This block is an SPI master that performs single-byte register reads and writes on a peripheral that has an irregular read protocol. A host presents a request made of a direction flag, a 7-bit register address and a write byte. The block turns that request into a series of separate byte transfers. Each transfer has its own chip-select window. Between transfers there are fixed waits measured in microseconds. The serial clock runs at 1 MHz in mode 0. The clock idles low, the peripheral samples on the rising edge and data changes on the falling edge.

A write sends a command byte with bit 7 clear and then sends the data byte at once. A 50 µs wait follows before completion. A read sends a command byte with bit 7 set and waits 50 µs. It then receives the result byte and waits 50 µs again. Next it receives one further byte, which it discards so that the peripheral stays in step, and it waits a final 50 µs. The outgoing line carries 0xFF during both receive bytes. Completion is marked by a one-cycle done pulse. The read result appears on the data output in the cycle of that pulse and holds there until the next read finishes.

The request side is a valid/ready handshake. A request transfers in any cycle where `req_valid` and `req_ready` are both high. The host must hold the request fields steady while `req_valid` is high and `req_ready` is low. `req_ready` is high only while the sequencer is idle, so back-pressure lasts for the whole transaction. The result side has no back-pressure: `rsp_done` is a bare pulse.

Top module: `spi_regseq`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sck` is 0, `busy` and `rsp_done` are 0, `req_ready` is 1 and `rsp_rdata` is 0x00.
- R2: `spi_sck` is low whenever `spi_cs_n` is high. `spi_mosi` never changes while `spi_sck` is high.
- R3: Within a byte, every high phase and every low phase of `spi_sck` lasts CLK_HZ/(2*SCK_HZ) system cycles (25 at the defaults). The low phase before the first rising edge also lasts that long.
- R4: The first byte of a transaction is sent MSB first. It is {1, address} for a read and {0, address} for a write.
- R5: On a write, the data byte (MSB first) follows the command byte after at most 8 cycles of `spi_cs_n` high. There is no microsecond wait between them.
- R6: On a read, `spi_cs_n` stays high for between GAP and GAP+8 cycles before the result byte and again before the dummy byte. GAP is GAP_US microseconds in system cycles (2500 at the defaults).
- R7: On a read, `spi_mosi` carries 0xFF during the result byte and during the dummy byte. The byte received during the result transfer becomes `rsp_rdata`. The dummy byte has no effect on `rsp_rdata`.
- R8: `rsp_done` rises between GAP and GAP+8 cycles after `spi_cs_n` rises at the end of the last byte.
- R9: `spi_cs_n` is low only during a byte transfer and is high during every wait. A read has exactly 3 chip-select windows and a write exactly 2, each with 8 rising clock edges.
- R10: A request is accepted only when `req_ready` is high. In the cycle after acceptance `busy` is 1 and `req_ready` is 0, and a request held during a transaction is not started until it ends.
- R11: `rsp_done` is high for exactly one cycle per transaction. `rsp_rdata` changes only in a cycle where `rsp_done` is high. A write leaves `rsp_rdata` unchanged.
- R12: In the cycle of the done pulse `req_ready` is already 1, so a waiting request is accepted in the same cycle as the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Register address |
| req_wdata | input | 8 | Byte to write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last read result, held |
| busy | output | 1 | Transaction in progress |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
Two events can fall in the same cycle: the completion pulse of one transaction and the acceptance of the next request. The bench provokes this by keeping `req_valid` high with the next request while the current one runs, and it chains several reads and writes this way. Every cycle in which `rsp_done`, `req_valid` and `req_ready` are all high is counted. The scoreboard then checks three things. The command bytes of the chained requests appear in order with nothing dropped or repeated. Each done pulse carries the result expected for its own transaction. `busy` is high again in the cycle after the pulse.

// File: rtl/spi_regseq_pkg.sv
package spi_regseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WAIT_A,
    ST_DATA,
    ST_WAIT_B,
    ST_DUMMY,
    ST_WAIT_C
  } seq_state_t;

  localparam logic [7:0] FILL_BYTE = 8'hFF;

  function automatic logic [7:0] cmd_byte(input logic is_rd, input logic [6:0] addr);
    return {is_rd, addr};
  endfunction

endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int HALF_CYC = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sck,
  output logic       mosi,
  output logic       cs_n,
  input  logic       miso
);
  localparam int HW = $clog2(HALF_CYC + 1);

  logic          active;
  logic [HW-1:0] half_cnt;
  logic [2:0]    bit_cnt;
  logic [7:0]    sh_tx;
  logic [7:0]    sh_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      half_cnt <= '0;
      bit_cnt  <= '0;
      sh_tx    <= '0;
      sh_rx    <= '0;
      sck      <= 1'b0;
      mosi     <= 1'b0;
      cs_n     <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active   <= 1'b1;
          cs_n     <= 1'b0;
          sh_tx    <= tx_byte;
          mosi     <= tx_byte[7];
          half_cnt <= '0;
          bit_cnt  <= '0;
          sck      <= 1'b0;
        end
      end else if (half_cnt == HW'(HALF_CYC - 1)) begin
        half_cnt <= '0;
        if (!sck) begin
          sck   <= 1'b1;
          sh_rx <= {sh_rx[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (bit_cnt == 3'd7) begin
            active <= 1'b0;
            cs_n   <= 1'b1;
            done   <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 3'd1;
            sh_tx   <= {sh_tx[6:0], 1'b0};
            mosi    <= sh_tx[6];
          end
        end
      end else begin
        half_cnt <= half_cnt + HW'(1);
      end
    end
  end

  assign rx_byte = sh_rx;

  assert_sck_low_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  assert_mosi_steady_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));

endmodule

// File: rtl/spi_gap_timer.sv
module spi_gap_timer #(
  parameter int GAP_CYC = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic running,
  output logic done
);
  localparam int GW = $clog2(GAP_CYC + 1);

  logic [GW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !running) begin
        cnt     <= GW'(GAP_CYC - 1);
        running <= 1'b1;
      end else if (running) begin
        if (cnt == '0) begin
          running <= 1'b0;
          done    <= 1'b1;
        end else begin
          cnt <= cnt - GW'(1);
        end
      end
    end
  end

  assert_done_ends_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(running));

endmodule

// File: rtl/spi_regseq.sv
module spi_regseq
  import spi_regseq_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int SCK_HZ = 1_000_000,
  parameter int GAP_US = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_write,
  input  logic [6:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       rsp_done,
  output logic [7:0] rsp_rdata,
  output logic       busy,
  output logic       spi_sck,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic       spi_cs_n
);
  localparam int HALF_CYC = CLK_HZ / (2 * SCK_HZ);
  localparam int GAP_CYC  = (CLK_HZ / 1_000_000) * GAP_US;

  seq_state_t state;
  logic       is_read;
  logic [7:0] wdata_q;
  logic [7:0] rx_hold;
  logic [7:0] tx_q;
  logic       x_go, x_done;
  logic [7:0] x_rx;
  logic       g_go, g_done, g_run;

  spi_byte_engine #(.HALF_CYC(HALF_CYC)) u_byte (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (x_go),
    .tx_byte (tx_q),
    .done    (x_done),
    .rx_byte (x_rx),
    .sck     (spi_sck),
    .mosi    (spi_mosi),
    .cs_n    (spi_cs_n),
    .miso    (spi_miso)
  );

  spi_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (g_go),
    .running (g_run),
    .done    (g_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      is_read   <= 1'b0;
      wdata_q   <= '0;
      rx_hold   <= '0;
      tx_q      <= '0;
      x_go      <= 1'b0;
      g_go      <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      x_go     <= 1'b0;
      g_go     <= 1'b0;
      rsp_done <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          is_read <= !req_write;
          wdata_q <= req_wdata;
          tx_q    <= cmd_byte(!req_write, req_addr);
          x_go    <= 1'b1;
          state   <= ST_CMD;
        end
        ST_CMD: if (x_done) begin
          if (is_read) begin
            g_go  <= 1'b1;
            state <= ST_WAIT_A;
          end else begin
            tx_q  <= wdata_q;
            x_go  <= 1'b1;
            state <= ST_DATA;
          end
        end
        ST_WAIT_A: if (g_done) begin
          tx_q  <= FILL_BYTE;
          x_go  <= 1'b1;
          state <= ST_DATA;
        end
        ST_DATA: if (x_done) begin
          if (is_read) rx_hold <= x_rx;
          g_go  <= 1'b1;
          state <= ST_WAIT_B;
        end
        ST_WAIT_B: if (g_done) begin
          if (is_read) begin
            tx_q  <= FILL_BYTE;
            x_go  <= 1'b1;
            state <= ST_DUMMY;
          end else begin
            rsp_done <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        ST_DUMMY: if (x_done) begin
          g_go  <= 1'b1;
          state <= ST_WAIT_C;
        end
        ST_WAIT_C: if (g_done) begin
          rsp_done  <= 1'b1;
          rsp_rdata <= rx_hold;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign req_ready = (state == ST_IDLE);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_done |-> $stable(rsp_rdata));

  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !req_ready));

  assert_cs_high_in_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    g_run |-> spi_cs_n);

endmodule

// File: tb/spi_regseq_tb_top.sv
module spi_regseq_tb_top;
  localparam int HALF = 25;
  localparam int GAP  = 2500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic spi_miso = 1'b1;
  logic req_ready, rsp_done, busy, spi_sck, spi_mosi, spi_cs_n;
  logic [7:0] rsp_rdata;

  always #10 clk = ~clk;

  spi_regseq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .busy(busy),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] exp_mosi[$];
  logic [7:0] miso_q[$];
  logic [7:0] exp_rd[$];
  bit         exp_long[$];
  int         exp_nbytes[$];
  logic [7:0] last_rd = 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // monitor: serial side and completion scoreboard
  logic prev_sck = 0, prev_cs = 1, prev_done = 0;
  logic [7:0] prev_rdata = 0, sh_in = 0, miso_sh = 0;
  int run_len = 0, bit_n = 0, bytes_in_txn = 0, last_rise = 0, coincide = 0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (spi_cs_n && spi_sck) check(0, "R2 sck high while deselected", 1, 0);
      if (prev_cs && !spi_cs_n) begin
        if (bytes_in_txn > 0) begin
          if (exp_long.size() == 0) check(0, "R9 unexpected extra byte", bytes_in_txn, 0);
          else begin
            automatic bit lg = exp_long.pop_front();
            automatic int iv = cyc - last_rise;
            if (lg) check(iv >= GAP && iv <= GAP + 8, "R6 read wait length", iv, GAP);
            else    check(iv <= 8, "R5 write no wait", iv, 2);
          end
        end
        begin
          automatic logic [7:0] b = (miso_q.size() > 0) ? miso_q.pop_front() : 8'hFF;
          spi_miso = b[7];
          miso_sh  = {b[6:0], 1'b0};
        end
        sh_in = 0; bit_n = 0; run_len = 1;
      end else if (!prev_sck && spi_sck) begin
        if (!spi_cs_n) check(run_len == HALF, "R3 sck low phase", run_len, HALF);
        sh_in = {sh_in[6:0], spi_mosi};
        bit_n++;
        run_len = 1;
      end else if (prev_sck && !spi_sck) begin
        check(run_len == HALF, "R3 sck high phase", run_len, HALF);
        spi_miso = miso_sh[7];
        miso_sh  = {miso_sh[6:0], 1'b0};
        run_len = 1;
      end else begin
        run_len++;
      end
      if (!prev_cs && spi_cs_n) begin
        check(bit_n == 8, "R9 edges per byte", bit_n, 8);
        if (exp_mosi.size() == 0) check(0, "R4 unexpected byte", sh_in, 0);
        else begin
          automatic logic [7:0] e = exp_mosi.pop_front();
          check(sh_in == e, "R4/R7 serial byte", sh_in, e);
        end
        bytes_in_txn++;
        last_rise = cyc;
      end
      if (rsp_done) begin
        automatic int iv = cyc - last_rise;
        check(!prev_done, "R11 done single cycle", 1, 0);
        check(iv >= GAP && iv <= GAP + 8, "R8 final wait", iv, GAP);
        if (exp_nbytes.size() > 0) begin
          automatic int nb = exp_nbytes.pop_front();
          check(bytes_in_txn == nb, "R9 byte windows", bytes_in_txn, nb);
        end else check(0, "R11 unexpected done", 1, 0);
        if (exp_rd.size() > 0) begin
          automatic logic [7:0] er = exp_rd.pop_front();
          check(rsp_rdata == er, "R7/R11 read result", rsp_rdata, er);
        end
        if (req_valid && req_ready) coincide++;
        bytes_in_txn = 0;
      end else if (rsp_rdata != prev_rdata) begin
        check(0, "R11 rdata changed without done", rsp_rdata, prev_rdata);
      end
      prev_sck = spi_sck; prev_cs = spi_cs_n; prev_done = rsp_done; prev_rdata = rsp_rdata;
    end
  end

  // driver: pushes expectations, then presents the request
  task automatic send(input bit w, input logic [6:0] a, input logic [7:0] d, input logic [7:0] rv);
    if (!w) begin
      exp_mosi.push_back({1'b1, a}); exp_mosi.push_back(8'hFF); exp_mosi.push_back(8'hFF);
      miso_q.push_back(8'h5A); miso_q.push_back(rv); miso_q.push_back(~rv ^ 8'h0F);
      exp_rd.push_back(rv); last_rd = rv;
      exp_long.push_back(1); exp_long.push_back(1);
      exp_nbytes.push_back(3);
    end else begin
      exp_mosi.push_back({1'b0, a}); exp_mosi.push_back(d);
      miso_q.push_back(8'hC3); miso_q.push_back(8'h99);
      exp_rd.push_back(last_rd);
      exp_long.push_back(0);
      exp_nbytes.push_back(2);
    end
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    check(busy && !req_ready, "R10 busy after accept", {busy, req_ready}, 2);
  endtask

  task automatic wait_all();
    req_valid = 0;
    while (busy || exp_nbytes.size() > 0) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(spi_cs_n == 1 && spi_sck == 0, "R1 serial idle", {spi_cs_n, spi_sck}, 2);
    check(!busy && req_ready && !rsp_done, "R1 control idle", {busy, req_ready, rsp_done}, 2);
    check(rsp_rdata == 8'h00, "R1 rdata", rsp_rdata, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    send(0, 7'h12, 8'h00, 8'h3C);
    wait_all();
    send(1, 7'h05, 8'hA7, 8'h00);
    wait_all();
    check(rsp_rdata == 8'h3C, "R11 write keeps rdata", rsp_rdata, 8'h3C);
    // chained requests: done pulse and next acceptance share a cycle (R12)
    send(0, 7'h7F, 8'h00, 8'hE1);
    send(1, 7'h00, 8'h00, 8'h00);
    send(0, 7'h40, 8'h00, 8'h81);
    send(1, 7'h7F, 8'hFF, 8'h00);
    wait_all();
    check(coincide == 3, "R12 accept in done cycle", coincide, 3);
    send(0, 7'h00, 8'h00, 8'hFF);
    wait_all();
    check(exp_mosi.size() == 0 && miso_q.size() == 0, "R9 all bytes seen",
          exp_mosi.size(), 0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog R10: actual=%0d expected=%0d", cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule